// File: doc/BRIEF.md
# Way-Predicted Two-Way Instruction Cache

This block is a two-way set-associative instruction cache that looks in only one way on a first lookup. The way it looks in is picked by the kind of fetch. A sequential fetch predicts way 0. A fetch of a taken-branch target predicts way 1. If the predicted way holds the line, the response arrives with the normal one-cycle latency. If the line sits in the other way instead, a second lookup finds it, and the same line comes back one cycle later, marked as a slow hit.

When neither way holds the line, the cache sends a line-aligned refill request to a simple memory port. It waits for the returned line and writes it into the predicted way. The other way in that set is not changed. It then answers the fetch with that line, marked as a miss. A busy output holds off the fetch side while a second lookup or a refill is under way.

Top module: `wp_icache`

## Requirements
- R1: While reset is low and right after it, every line is invalid and busy, rsp_valid and mem_req_valid are low. The first fetch of any address after a reset is a miss.
- R2: A fetch is accepted at a rising clock edge when req_valid is high and busy is low. The first lookup enables exactly one way: way 0 when req_branch is 0 (sequential), way 1 when req_branch is 1 (branch target). No more than one way is ever enabled at a time.
- R3: A fast hit (line in the predicted way) gives rsp_valid high in the cycle right after acceptance, with rsp_status 2'b01. Busy stays low.
- R4: A slow hit (predicted way misses, other way holds the line) gives busy high in the cycle after acceptance. The response follows one cycle later with rsp_status 2'b10.
- R5: The returned line is the line stored for that address, whichever way it sits in and whether the hit is fast or slow.
- R6: On a miss in both ways, mem_req_valid goes high two cycles after acceptance. mem_req_addr is the fetch address with its offset bits forced to zero. Both stay steady until mem_req_ready is seen high at a clock edge.
- R7: The refill line is written only into the predicted way of the addressed set. Whatever the other way held stays there.
- R8: The cycle after mem_rsp_valid is seen, rsp_valid is high with rsp_status 2'b11 and rsp_line equal to the returned memory line.
- R9: Requests presented while busy is high are ignored: they produce no response and change no cache content.
- R10: rsp_status reads 2'b00 whenever rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fetch request present |
| req_addr | input | ADDR_W | Fetch byte address |
| req_branch | input | 1 | 1 = branch-target fetch, 0 = sequential fetch |
| busy | output | 1 | Second lookup or refill in progress; requests ignored |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_status | output | 2 | 00 none, 01 fast hit, 10 slow hit, 11 miss |
| rsp_line | output | LINE_BYTES*8 | Instruction line for the fetch |
| mem_req_valid | output | 1 | Refill request to memory |
| mem_req_addr | output | ADDR_W | Line-aligned refill address |
| mem_req_ready | input | 1 | Memory takes the refill request |
| mem_rsp_valid | input | 1 | Refill line present |
| mem_rsp_line | input | LINE_BYTES*8 | Returned refill line |

## Verification
The bench builds the cache with a 16-bit address, 4-byte lines and 4 sets. This leaves only a few sets and a short tag, so a small pool of addresses forces repeated set conflicts. Those conflicts bring all three outcomes within reach, along with refills that overwrite one way while the other survives. Random fetch types, random offsets inside a line, random memory handshake delays and stray requests during refills are mixed with a directed conflict sequence and a mid-run reset.

// File: rtl/wp_icache_pkg.sv
package wp_icache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PROBE2  = 2'd1,
    ST_MEMREQ  = 2'd2,
    ST_MEMWAIT = 2'd3
  } wp_state_e;

  localparam logic [1:0] CODE_NONE = 2'b00;
  localparam logic [1:0] CODE_FAST = 2'b01;
  localparam logic [1:0] CODE_SLOW = 2'b10;
  localparam logic [1:0] CODE_MISS = 2'b11;

  // one-hot enable for a single way
  function automatic logic [1:0] way_onehot(input logic w);
    return w ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/wp_icache_tag_way.sv
module wp_icache_tag_way #(
  parameter int SETS  = 64,
  parameter int IDX_W = 6,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  input  logic             wr_en,
  output logic             hit
);

  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[idx] <= tag;
  end

  // a way that is not enabled never reports a hit
  assign hit = rd_en && valid_q[idx] && (tag_q[idx] == tag);

endmodule

// File: rtl/wp_icache_data_way.sv
module wp_icache_data_way #(
  parameter int SETS   = 64,
  parameter int IDX_W  = 6,
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  output logic [LINE_W-1:0] rd_line
);

  logic [LINE_W-1:0] line_q [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) line_q[idx] <= wr_line;
  end

  assign rd_line = line_q[idx];

endmodule

// File: rtl/wp_icache_ctrl.sv
module wp_icache_ctrl
  import wp_icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_branch,
  input  logic [1:0]        way_hit,
  output logic [1:0]        probe_en,
  output logic [IDX_W-1:0]  look_idx,
  output logic [TAG_W-1:0]  look_tag,
  output logic              rd_way,
  output logic [1:0]        fill_en,
  output logic              busy,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  output logic              rsp_load,
  output logic              rsp_from_mem,
  output logic [1:0]        rsp_code,
  output logic              fast_hit_ev,
  output logic              slow_hit_ev,
  output logic              miss_ev,
  output logic              refill_ev
);

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-OFF_W-1:0] l);
    return {l, {OFF_W{1'b0}}};
  endfunction

  wp_state_e                state_q, state_d;
  logic [ADDR_W-OFF_W-1:0]  line_q;
  logic                     branch_q;
  logic                     accept;
  logic [ADDR_W-1:0]        cur_addr;
  logic                     pred;

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign cur_addr = (state_q == ST_IDLE) ? req_addr : line_base(line_q);
  assign pred     = (state_q == ST_IDLE) ? req_branch : branch_q;
  assign look_idx = idx_of(cur_addr);
  assign look_tag = tag_of(cur_addr);
  assign busy     = (state_q != ST_IDLE);

  assign rd_way   = (state_q == ST_PROBE2) ? ~pred : pred;

  always_comb begin
    probe_en = 2'b00;
    if (accept)                    probe_en = way_onehot(pred);
    else if (state_q == ST_PROBE2) probe_en = way_onehot(~pred);
  end

  assign fast_hit_ev = accept && way_hit[pred];
  assign slow_hit_ev = (state_q == ST_PROBE2) && way_hit[~pred];
  assign miss_ev     = (state_q == ST_PROBE2) && !way_hit[~pred];
  assign refill_ev   = (state_q == ST_MEMWAIT) && mem_rsp_valid;

  assign fill_en       = refill_ev ? way_onehot(pred) : 2'b00;
  assign mem_req_valid = (state_q == ST_MEMREQ);
  assign mem_req_addr  = line_base(line_q);

  assign rsp_load     = fast_hit_ev || slow_hit_ev || refill_ev;
  assign rsp_from_mem = refill_ev;
  assign rsp_code     = fast_hit_ev ? CODE_FAST :
                        slow_hit_ev ? CODE_SLOW : CODE_MISS;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept && !way_hit[pred]) state_d = ST_PROBE2;
      ST_PROBE2:  state_d = way_hit[~pred] ? ST_IDLE : ST_MEMREQ;
      ST_MEMREQ:  if (mem_req_ready) state_d = ST_MEMWAIT;
      ST_MEMWAIT: if (mem_rsp_valid) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      line_q   <= '0;
      branch_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        line_q   <= req_addr[ADDR_W-1:OFF_W];
        branch_q <= req_branch;
      end
    end
  end

endmodule

// File: rtl/wp_icache.sv
module wp_icache
  import wp_icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_branch,
  output logic                    busy,
  output logic                    rsp_valid,
  output logic [1:0]              rsp_status,
  output logic [LINE_BYTES*8-1:0] rsp_line,
  output logic                    mem_req_valid,
  output logic [ADDR_W-1:0]       mem_req_addr,
  input  logic                    mem_req_ready,
  input  logic                    mem_rsp_valid,
  input  logic [LINE_BYTES*8-1:0] mem_rsp_line
);

  localparam int LINE_W = LINE_BYTES * 8;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WAYS   = 2;

  logic [1:0]        probe_en;
  logic [1:0]        way_hit;
  logic [1:0]        fill_en;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;
  logic              rd_way;
  logic              rsp_load;
  logic              rsp_from_mem;
  logic [1:0]        rsp_code;
  logic              fast_hit_ev;
  logic              slow_hit_ev;
  logic              miss_ev;
  logic              refill_ev;
  logic [LINE_W-1:0] way_line [WAYS];
  logic [LINE_W-1:0] sel_line;

  wp_icache_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_branch(req_branch),
    .way_hit(way_hit), .probe_en(probe_en),
    .look_idx(look_idx), .look_tag(look_tag), .rd_way(rd_way),
    .fill_en(fill_en), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .rsp_load(rsp_load), .rsp_from_mem(rsp_from_mem), .rsp_code(rsp_code),
    .fast_hit_ev(fast_hit_ev), .slow_hit_ev(slow_hit_ev),
    .miss_ev(miss_ev), .refill_ev(refill_ev)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    wp_icache_tag_way #(
      .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) tag_i (
      .clk(clk), .rst_n(rst_n), .rd_en(probe_en[w]),
      .idx(look_idx), .tag(look_tag), .wr_en(fill_en[w]), .hit(way_hit[w])
    );
    wp_icache_data_way #(
      .SETS(SETS), .IDX_W(IDX_W), .LINE_W(LINE_W)
    ) data_i (
      .clk(clk), .idx(look_idx), .wr_en(fill_en[w]),
      .wr_line(mem_rsp_line), .rd_line(way_line[w])
    );
  end

  assign sel_line = rd_way ? way_line[1] : way_line[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= CODE_NONE;
      rsp_line   <= '0;
    end else begin
      rsp_valid  <= rsp_load;
      rsp_status <= rsp_load ? rsp_code : CODE_NONE;
      if (rsp_load) rsp_line <= rsp_from_mem ? mem_rsp_line : sel_line;
    end
  end

endmodule

// File: rtl/wp_icache_chk.sv
module wp_icache_chk #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              rsp_valid,
  input logic [1:0]        rsp_status,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_req_ready,
  input logic [1:0]        probe_en,
  input logic [1:0]        fill_en,
  input logic              fast_hit_ev,
  input logic              slow_hit_ev,
  input logic              refill_ev
);

  AST_PROBE_SINGLE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_en)); // R2

  AST_FAST_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fast_hit_ev |=> rsp_valid && rsp_status == 2'b01 && !busy); // R3

  AST_SLOW_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'b10) |-> $past(busy)); // R4

  AST_SLOW_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    slow_hit_ev |=> rsp_valid && rsp_status == 2'b10); // R4

  AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr)); // R6

  AST_FILL_SINGLE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_en)); // R7

  AST_MISS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    refill_ev |=> rsp_valid && rsp_status == 2'b11); // R8

  AST_NO_FAST_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> !(rsp_valid && rsp_status == 2'b01)); // R9

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> rsp_status == 2'b00); // R10

endmodule

bind wp_icache wp_icache_chk #(
  .ADDR_W(ADDR_W), .LINE_W(LINE_BYTES*8)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status),
  .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .mem_req_ready(mem_req_ready), .probe_en(probe_en), .fill_en(fill_en),
  .fast_hit_ev(fast_hit_ev), .slow_hit_ev(slow_hit_ev), .refill_ev(refill_ev)
);

// File: tb/wp_icache_tb_top.sv
module wp_icache_tb_top;

  localparam int AW   = 16;
  localparam int LB   = 4;
  localparam int NS   = 4;
  localparam int LW   = LB * 8;
  localparam int OFFB = 2;
  localparam int IDXB = 2;
  localparam int TAGB = AW - OFFB - IDXB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_branch = 1'b0;
  logic          busy, rsp_valid, mem_req_valid;
  logic [1:0]    rsp_status;
  logic [LW-1:0] rsp_line;
  logic [AW-1:0] mem_req_addr;
  logic          mem_req_ready = 1'b0;
  logic          mem_rsp_valid = 1'b0;
  logic [LW-1:0] mem_rsp_line = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic            ref_v [2][NS];
  logic [TAGB-1:0] ref_t [2][NS];
  logic [LW-1:0]   ref_l [2][NS];

  always #2.5 clk = ~clk;

  wp_icache #(.ADDR_W(AW), .LINE_BYTES(LB), .SETS(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_branch(req_branch), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_line(rsp_line),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_line(mem_rsp_line)
  );

  function automatic logic [LW-1:0] mem_content(input logic [AW-1:0] a);
    logic [AW-1:0] base = a & ~AW'(LB - 1);
    return {base ^ 16'h5A3C, ~base};
  endfunction

  function automatic int set_of(input logic [AW-1:0] a);
    return int'((a / LB) % NS);
  endfunction

  function automatic logic [TAGB-1:0] tag_of(input logic [AW-1:0] a);
    return TAGB'(a / (LB * NS));
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!rsp_valid && !busy && !mem_req_valid, "R1",
          {rsp_valid, busy, mem_req_valid}, 3'b000);
    rst_n = 1'b1;
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < NS; s++) ref_v[w][s] = 1'b0;
    @(negedge clk);
  endtask

  // one fetch from request to idle, with memory handshake and optional stray request
  task automatic fetch(input logic [AW-1:0] a, input logic br, input int rdy_dly,
                       input int rsp_dly, input bit stray);
    int s = set_of(a);
    logic [TAGB-1:0] t = tag_of(a);
    bit hp = ref_v[br][s] && ref_t[br][s] == t;
    bit ho = ref_v[!br][s] && ref_t[!br][s] == t;
    logic [LW-1:0] exp_line = mem_content(a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_branch = br;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (hp) begin
      check(rsp_valid && rsp_status == 2'b01 && !busy, "R3 fast hit",
            {rsp_valid, rsp_status, busy}, 4'b1010);
      check(rsp_line == exp_line, "R5 fast line", rsp_line, exp_line);
    end else begin
      check(!rsp_valid && busy, "R4/R8 busy after lookup miss",
            {rsp_valid, busy}, 2'b01);
      @(negedge clk);
      if (ho) begin
        check(rsp_valid && rsp_status == 2'b10, "R4 slow hit",
              {rsp_valid, rsp_status}, 3'b110);
        check(rsp_line == exp_line, "R5 slow line", rsp_line, exp_line);
      end else begin
        check(mem_req_valid && mem_req_addr == (a & ~AW'(LB - 1)), "R6 refill request",
              {mem_req_valid, mem_req_addr}, {1'b1, a & ~AW'(LB - 1)});
        if (stray) begin
          req_valid = 1'b1; req_addr = a ^ 16'h0040; req_branch = !br;
        end
        for (int i = 0; i < rdy_dly; i++) begin
          @(negedge clk);
          check(mem_req_valid && mem_req_addr == (a & ~AW'(LB - 1)), "R6 request held",
                {mem_req_valid, mem_req_addr}, {1'b1, a & ~AW'(LB - 1)});
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check(!mem_req_valid && busy, "R6 request dropped", {mem_req_valid, busy}, 2'b01);
        for (int i = 0; i < rsp_dly; i++) @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_line = exp_line; req_valid = 1'b0;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check(rsp_valid && rsp_status == 2'b11 && rsp_line == exp_line, "R8 miss response",
              {rsp_valid, rsp_status, rsp_line}, {1'b1, 2'b11, exp_line});
        ref_v[br][s] = 1'b1; ref_t[br][s] = t; ref_l[br][s] = exp_line;  // R7 other way kept
      end
    end
    @(negedge clk);
    check(!rsp_valid && rsp_status == 2'b00, "R9/R10 idle after response",
          {rsp_valid, rsp_status}, 3'b000);
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // directed conflict sequence in set 1
    fetch(16'h0104, 1'b0, 0, 0, 1'b0);  // R1 cold miss fills way 0
    fetch(16'h0106, 1'b0, 0, 0, 1'b0);  // R3 fast
    fetch(16'h0105, 1'b1, 1, 2, 1'b0);  // R2 R4 slow via way 0
    fetch(16'h0104, 1'b1, 0, 0, 1'b0);  // slow hits do not move the line
    fetch(16'h0204, 1'b1, 2, 1, 1'b1);  // R7 miss fills way 1, stray ignored R9
    fetch(16'h0104, 1'b0, 0, 0, 1'b0);  // way 0 untouched
    fetch(16'h0207, 1'b0, 0, 0, 1'b0);  // slow via way 1
    fetch(16'h0304, 1'b0, 3, 3, 1'b0);  // replaces way 0
    fetch(16'h0104, 1'b1, 0, 0, 1'b0);  // now a miss
    fetch(16'h0304, 1'b0, 0, 0, 1'b0);  // fast
    // random traffic over a small address pool
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      a = {4'($urandom_range(0, 2)), 8'h00, 2'($urandom_range(0, 3)),
           2'($urandom_range(0, 3))};
      fetch(a, 1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, 3),
            ($urandom_range(0, 3) == 0));
    end
    // R1 reset invalidates everything
    do_reset();
    fetch(16'h0304, 1'b0, 0, 0, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule